// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer execution slice of a processor datapath that computes a result from two operands and keeps a four-bit condition state (negative, zero, carry, overflow) for later conditional instructions. It offers addition, addition with the stored carry, subtraction, subtraction with the stored carry, bitwise AND, and bit-clear (first operand AND the complement of the second). The arithmetic and logic paths are combinational. The flag state is held in a register that changes on the rising clock edge.

A width select runs each operation on the full 64-bit operands or on their low 32 bits. In the 32-bit case the upper result half is zero, and every flag comes from the low half alone. A per-operation set-flags enable decides whether the flag register takes the new value. A compare mode updates the flags but suppresses the result write, so it serves as a flag-only test: subtraction gives a compare, and AND gives a bit test.

Top module: `alu_nzcv_core`

## Requirements
- R1: N takes the top bit of the result at the selected width (bit 63 or bit 31), and Z is 1 exactly when the result at that width is zero; the flags output packs N at bit 3, Z at bit 2, C at bit 1 and V at bit 0.
- R2: Opcode 0 (add) yields A+B; C is the carry out of the top bit, and V is 1 when both operands share a sign that differs from the sign of the result.
- R3: Opcode 2 (subtract) yields A-B computed as A+~B+1; C is the carry out of that sum, so 1 means no borrow, and V is 1 when the operands differ in sign and the result sign differs from A.
- R4: Opcode 1 (add with carry) yields A+B+C, using the C held in the flag register.
- R5: Opcode 3 (subtract with carry) yields A-B-(1-C), computed as A+~B+C, with C and V produced as for opcode 2.
- R6: Opcode 4 (AND) yields A&B and opcode 5 (bit-clear) yields A&~B; both set N and Z from the result and clear C and V to 0.
- R7: With compare mode high, wr_en is low and all four flags are updated even if set-flags is low.
- R8: With set-flags low and compare mode low, the flags keep their value across the clock edge.
- R9: With wide_mode low (32-bit), result bits 63:32 are 0, upper operand bits have no effect, and carry and overflow are taken at bit 31.
- R10: An active-low reset clears the flags to 4'b0000 at once.
- R11: Opcodes 6 and 7 give a zero result, hold wr_en low and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | Operation: 0 add, 1 add+carry, 2 sub, 3 sub+carry, 4 AND, 5 bit-clear |
| wide_mode | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| set_flags | input | 1 | Update the flags with this operation |
| cmp_mode | input | 1 | Flag-only operation: no result write |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| result | output | 64 | Operation result |
| wr_en | output | 1 | Result write enable |
| flags | output | 4 | Stored N,Z,C,V (bit 3 down to bit 0) |

## Verification
The bench builds the block with its default 64-bit data width and 32-bit half width. Both operating sizes are then reachable through wide_mode. This brings the two carry and overflow tap points, bit 63 and bit 31, into the same run. It also lets a chain of vectors show the stored carry feeding the carry-using operations at both widths.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_BIC = 3'd5
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned HALF_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              invert_b,
  input  logic              use_flag_c,
  input  logic              flag_c,
  input  logic              wide,
  output logic [DATA_W-1:0] sum,
  output logic              carry_out,
  output logic              ovf_out
);
  localparam int unsigned UPPER_W = DATA_W - HALF_W;

  function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] x, input logic w);
    return w ? x : {{UPPER_W{1'b0}}, x[HALF_W-1:0]};
  endfunction

  function automatic logic top_bit(input logic [DATA_W-1:0] x, input logic w);
    return w ? x[DATA_W-1] : x[HALF_W-1];
  endfunction

  logic [DATA_W-1:0] a_m, b_m;
  logic              cin;
  logic [DATA_W:0]   full;

  always_comb begin
    a_m  = fit(opa, wide);
    b_m  = fit(invert_b ? ~opb : opb, wide);
    cin  = use_flag_c ? flag_c : invert_b;
    full = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, cin};
    sum  = fit(full[DATA_W-1:0], wide);
    carry_out = wide ? full[DATA_W] : full[HALF_W];
    ovf_out   = (top_bit(a_m, wide) == top_bit(b_m, wide)) &&
                (top_bit(sum, wide) != top_bit(a_m, wide));
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned HALF_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              clear_mode,
  input  logic              wide,
  output logic [DATA_W-1:0] res
);
  localparam int unsigned UPPER_W = DATA_W - HALF_W;

  logic [DATA_W-1:0] raw;

  always_comb begin
    raw = opa & (clear_mode ? ~opb : opb);
    res = wide ? raw : {{UPPER_W{1'b0}}, raw[HALF_W-1:0]};
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flags_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  flags_t nxt,
  output flags_t cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cur <= '0;
    else if (upd) cur <= nxt;
  end

  // R8: without an update the stored flags do not move
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(cur));

  // R10: a cycle in reset leaves the flags cleared
  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n |-> cur == 4'b0000);
endmodule

// File: rtl/alu_nzcv_core.sv
module alu_nzcv_core
  import alu_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic              wide_mode,
  input  logic              set_flags,
  input  logic              cmp_mode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [3:0]        flags
);
  localparam int unsigned UPPER_W = DATA_W - HALF_W;

  logic is_arith, is_logic, is_sub, use_c, is_clear, op_ok, upd;
  logic [DATA_W-1:0] arith_res, logic_res, res_w;
  logic   c_arith, v_arith, n_w, z_w;
  flags_t cur, nxt;

  always_comb begin
    is_arith = 1'b0;
    is_logic = 1'b0;
    is_sub   = 1'b0;
    use_c    = 1'b0;
    is_clear = 1'b0;
    case (op_code)
      OP_ADD: is_arith = 1'b1;
      OP_ADC: begin is_arith = 1'b1; use_c = 1'b1; end
      OP_SUB: begin is_arith = 1'b1; is_sub = 1'b1; end
      OP_SBC: begin is_arith = 1'b1; is_sub = 1'b1; use_c = 1'b1; end
      OP_AND: is_logic = 1'b1;
      OP_BIC: begin is_logic = 1'b1; is_clear = 1'b1; end
      default: ;
    endcase
    op_ok = is_arith | is_logic;
  end

  alu_addsub #(.DATA_W(DATA_W), .HALF_W(HALF_W)) addsub_i (
    .opa(src_a), .opb(src_b), .invert_b(is_sub), .use_flag_c(use_c),
    .flag_c(cur.c), .wide(wide_mode), .sum(arith_res),
    .carry_out(c_arith), .ovf_out(v_arith)
  );

  alu_logic #(.DATA_W(DATA_W), .HALF_W(HALF_W)) logic_i (
    .opa(src_a), .opb(src_b), .clear_mode(is_clear), .wide(wide_mode),
    .res(logic_res)
  );

  always_comb begin
    res_w = is_arith ? arith_res : (is_logic ? logic_res : '0);
    n_w   = wide_mode ? res_w[DATA_W-1] : res_w[HALF_W-1];
    z_w   = (res_w == '0);
    nxt   = '{n: n_w, z: z_w, c: is_arith & c_arith, v: is_arith & v_arith};
    upd   = op_ok & (set_flags | cmp_mode);
  end

  alu_flag_reg flag_reg_i (
    .clk(clk), .rst_n(rst_n), .upd(upd), .nxt(nxt), .cur(cur)
  );

  assign result = res_w;
  assign wr_en  = op_ok & ~cmp_mode;
  assign flags  = cur;

  // R7: a compare never writes its result
  a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_mode |-> !wr_en);

  // R7: a valid compare always refreshes the flags
  a_r7_cmp_updates: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && op_ok) |=> flags == $past(nxt));

  // R6: logical operations leave C and V cleared
  a_r6_logic_cv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && is_logic) |=> flags[1:0] == 2'b00);

  // R1: stored Z matches a zero result seen at the port
  a_r1_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flags[2] == ($past(result) == '0));

  // R9: narrow mode keeps the upper half clear
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |-> result[DATA_W-1:HALF_W] == {UPPER_W{1'b0}});

  // R11: undefined opcodes neither write nor disturb the flags
  a_r11_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ok |-> (result == '0 && !wr_en) ##1 $stable(flags));
endmodule

// File: tb/alu_nzcv_core_tb.sv
`timescale 1ns/1ps
module alu_nzcv_core_tb_top;
  typedef struct packed {
    logic [2:0]  op;
    logic        w64;
    logic        sf;
    logic        cmp;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic        wr;
    logic [3:0]  fl;
  } vec_t;

  localparam int NV = 18;
  // flags column: {N,Z,C,V}
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b1, 1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000, 1'b1, 4'b1001},
    '{3'd0, 1'b0, 1'b1, 1'b0, 64'hDEAD_BEEF_7FFF_FFFF, 64'h1111_1111_7FFF_FFFF, 64'h0000_0000_FFFF_FFFE, 1'b1, 4'b1001},
    '{3'd0, 1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 1'b1, 4'b0110},
    '{3'd1, 1'b1, 1'b1, 1'b0, 64'h5, 64'h6, 64'hC, 1'b1, 4'b0000},
    '{3'd1, 1'b1, 1'b0, 1'b0, 64'h5, 64'h6, 64'hB, 1'b1, 4'b0000},
    '{3'd2, 1'b1, 1'b1, 1'b0, 64'h5, 64'h5, 64'h0, 1'b1, 4'b0110},
    '{3'd3, 1'b1, 1'b1, 1'b0, 64'hA, 64'h3, 64'h7, 1'b1, 4'b0010},
    '{3'd2, 1'b1, 1'b1, 1'b0, 64'h3, 64'h5, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 4'b1000},
    '{3'd3, 1'b1, 1'b1, 1'b0, 64'hA, 64'h3, 64'h6, 1'b1, 4'b0010},
    '{3'd2, 1'b0, 1'b1, 1'b0, 64'h8000_0000, 64'h1, 64'h7FFF_FFFF, 1'b1, 4'b0011},
    '{3'd4, 1'b1, 1'b1, 1'b0, 64'hFFFF_0000_0000_0000, 64'h8000_0000_0000_00FF, 64'h8000_0000_0000_0000, 1'b1, 4'b1000},
    '{3'd5, 1'b0, 1'b1, 1'b0, 64'h0000_0000_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 4'b0100},
    '{3'd2, 1'b1, 1'b0, 1'b1, 64'h1, 64'h2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'b1000},
    '{3'd2, 1'b1, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 4'b0011},
    '{3'd0, 1'b1, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 1'b1, 4'b0111},
    '{3'd0, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF, 64'h2, 64'h1, 1'b1, 4'b0111},
    '{3'd2, 1'b1, 1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1, 4'b1001},
    '{3'd6, 1'b1, 1'b1, 1'b0, 64'h1234, 64'h5678, 64'h0, 1'b0, 4'b1001}
  };
  // requirement tag for each vector
  localparam string TAG [NV] = '{"R2", "R9", "R1", "R4", "R8", "R3", "R5", "R3", "R5",
                                 "R9", "R6", "R6", "R7", "R3", "R2", "R9", "R3", "R11"};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_code;
  logic        wide_mode, set_flags, cmp_mode;
  logic [63:0] src_a, src_b, result;
  logic        wr_en;
  logic [3:0]  flags;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  alu_nzcv_core dut_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .wide_mode(wide_mode),
    .set_flags(set_flags), .cmp_mode(cmp_mode), .src_a(src_a), .src_b(src_b),
    .result(result), .wr_en(wr_en), .flags(flags)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_code = 3'd0; wide_mode = 1'b1; set_flags = 1'b0;
    cmp_mode = 1'b0; src_a = '0; src_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "flags in reset", {60'd0, flags}, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op_code = VEC[i].op; wide_mode = VEC[i].w64; set_flags = VEC[i].sf;
      cmp_mode = VEC[i].cmp; src_a = VEC[i].a; src_b = VEC[i].b;
      #1;
      chk(TAG[i], "result", result, VEC[i].res);
      chk(TAG[i], "wr_en", {63'd0, wr_en}, {63'd0, VEC[i].wr});
      @(posedge clk);
      #1;
      chk(TAG[i], "flags", {60'd0, flags}, {60'd0, VEC[i].fl});
    end

    // R11: opcode 7 also leaves flags 1001 untouched
    @(negedge clk);
    op_code = 3'd7; set_flags = 1'b1; cmp_mode = 1'b0; src_a = 64'hFF; src_b = 64'h1;
    #1;
    chk("R11", "result op7", result, 64'h0);
    chk("R11", "wr_en op7", {63'd0, wr_en}, 64'h0);
    @(posedge clk);
    #1;
    chk("R11", "flags op7", {60'd0, flags}, 64'h9);

    // R7: compare with AND (bit test) sets flags while set_flags is low
    @(negedge clk);
    op_code = 3'd4; set_flags = 1'b0; cmp_mode = 1'b1; wide_mode = 1'b1;
    src_a = 64'hF0; src_b = 64'h0F;
    #1;
    chk("R7", "wr_en test", {63'd0, wr_en}, 64'h0);
    @(posedge clk);
    #1;
    chk("R7", "flags test", {60'd0, flags}, 64'h4);

    // R10: reset clears flags without waiting for a clock edge
    @(negedge clk);
    op_code = 3'd2; cmp_mode = 1'b0; set_flags = 1'b1; src_a = 64'h1; src_b = 64'h2;
    @(posedge clk);
    #1;
    chk("R3", "flags before reset", {60'd0, flags}, 64'h8);
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R10", "flags async reset", {60'd0, flags}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1; set_flags = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule